// File: doc/BRIEF.md
# Dual-Branch Clock-Enable Divider

This block holds the digital divider network that sits around a frequency-multiplying PLL. On the oscillator side, a prescaler takes a 4-bit code and divides the primary oscillator down to the fixed 4 MHz PLL reference. It produces a one-cycle reference enable and a flag that reports whether the code is usable. The only legal oscillator rates are 4, 8, 12, 16, 20, 24, 32 and 48 MHz. When the internal RC oscillator is the source, only the 4 MHz and 8 MHz settings apply.

On the fast side, the 96 MHz multiplied clock feeds two branches. Each branch produces a one-cycle clock enable rather than a divided clock, so odd ratios need no duty-cycle correction.

- **USB branch:** a fixed divide-by-2 gives a 48 MHz enable. This enable is gated off while USB is disabled or suspended.
- **System branch:** a fixed divide-by-3 stage feeds a 2-bit postscaler, giving 32, 16, 8 or 4 MHz.

A configuration-error flag is raised when a postscaler setting that is too slow for USB is chosen while USB is enabled. Changing either code restarts the counters it governs. The first new enable therefore arrives one full new period after the change.

Top module: `clkdiv_top`

## Requirements
- R1: While `rst` is high at a clock edge, every counter clears and `refEn`, `usbClkEn` and `sysClkEn` are low after that edge.
- R2: With a valid code held, `refEn` pulses once every N oscillator cycles. N is 1, 2, 3, 4, 5, 6, 8 or 12 for `preCode` 0000 through 0111 respectively.
- R3: `preCode` values 1000 to 1111 drive `preCodeValid` low, and `refEn` stays low while they are applied.
- R4: With `srcIsRc` high, only `preCode` 0000 and 0001 are valid. Any other code drives `preCodeValid` low and keeps `refEn` low.
- R5: `usbClkEn` pulses every second PLL cycle while `usbEnable` is high and `usbSuspend` is low, and stays low otherwise.
- R6: `sysClkEn` pulses once every 3·D PLL cycles. D is 1, 2, 4 or 8 for `postCode` 00, 01, 10 or 11.
- R7: `cfgErr` is high exactly when `usbEnable` is high and `postCode` is 10 or 11.
- R8: A change of `preCode` restarts the prescaler. `refEn` is low on the cycle of the change, and the first new pulse comes N cycles after the edge that sees the new code.
- R9: A change of `postCode` restarts both system counters. The first new `sysClkEn` comes 3·D cycles after the edge that sees the new code.
- R10: Each enable output is high for a single cycle whenever its ratio exceeds 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkOsc | input | 1 | Primary oscillator clock |
| clkPll | input | 1 | Multiplied (96 MHz) PLL clock |
| rst | input | 1 | Synchronous active-high reset, both domains |
| preCode | input | 4 | Prescaler ratio code |
| srcIsRc | input | 1 | Oscillator input comes from the internal RC source |
| postCode | input | 2 | System postscaler code |
| usbEnable | input | 1 | USB function enabled |
| usbSuspend | input | 1 | USB function suspended |
| refEn | output | 1 | One-cycle PLL reference enable (oscillator domain) |
| preCodeValid | output | 1 | Prescaler code is legal for the chosen source |
| usbClkEn | output | 1 | One-cycle 48 MHz USB enable |
| sysClkEn | output | 1 | One-cycle system clock enable |
| cfgErr | output | 1 | Slow system setting chosen with USB enabled |

## Verification
A code change and an enable pulse that was already due can fall on the same edge. The restart must win, and the pulse must be suppressed. The bench provokes this by switching `preCode` and `postCode` exactly on the cycle in which the old ratio would have fired. It then judges the outcome against a behavioural model that counts edges since the last restart, comparing every output on every cycle. A second case puts a postscaler change that raises `cfgErr` into the same cycle as a USB gating change, and each output is judged independently.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int PRE_CODE_W  = 4;
  localparam int PRE_CNT_W   = 4;
  localparam int POST_CODE_W = 2;
  localparam int POST_CNT_W  = (1 << POST_CODE_W) - 1;

  // Strobes and terminal counts passed from control to datapath
  typedef struct packed {
    logic                  preRun;
    logic                  preRestart;
    logic [PRE_CNT_W-1:0]  preLast;
    logic                  usbActive;
    logic                  sysRestart;
    logic [POST_CNT_W-1:0] postLast;
  } divCtrl_t;

  // Non-linear code to (ratio - 1) map for the legal prescaler codes
  function automatic logic [PRE_CNT_W-1:0] preLastOf(input logic [2:0] sel);
    case (sel)
      3'd0:    preLastOf = PRE_CNT_W'(0);
      3'd1:    preLastOf = PRE_CNT_W'(1);
      3'd2:    preLastOf = PRE_CNT_W'(2);
      3'd3:    preLastOf = PRE_CNT_W'(3);
      3'd4:    preLastOf = PRE_CNT_W'(4);
      3'd5:    preLastOf = PRE_CNT_W'(5);
      3'd6:    preLastOf = PRE_CNT_W'(7);
      default: preLastOf = PRE_CNT_W'(11);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic                   clkOsc,
  input  logic                   clkPll,
  input  logic                   rst,
  input  logic [PRE_CODE_W-1:0]  preCode,
  input  logic                   srcIsRc,
  input  logic [POST_CODE_W-1:0] postCode,
  input  logic                   usbEnable,
  input  logic                   usbSuspend,
  output divCtrl_t               ctrl,
  output logic                   preCodeValid,
  output logic                   cfgErr
);
  localparam int RC_MAX_CODE = 1;
  localparam int SLOW_MIN    = 2;

  logic [PRE_CODE_W-1:0]  prevPre;
  logic [POST_CODE_W-1:0] prevPost;
  logic                   codeInRange;
  logic                   rcOk;

  always_ff @(posedge clkOsc) begin
    prevPre <= preCode;
  end

  always_ff @(posedge clkPll) begin
    prevPost <= postCode;
  end

  always_comb begin
    codeInRange  = (preCode[PRE_CODE_W-1:3] == '0);
    rcOk         = !srcIsRc || (int'(preCode) <= RC_MAX_CODE);
    preCodeValid = codeInRange && rcOk;
    cfgErr       = usbEnable && (int'(postCode) >= SLOW_MIN);

    ctrl.preRun     = preCodeValid;
    ctrl.preRestart = (preCode != prevPre);
    ctrl.preLast    = preLastOf(preCode[2:0]);
    ctrl.usbActive  = usbEnable && !usbSuspend;
    ctrl.sysRestart = (postCode != prevPost);
    ctrl.postLast   = POST_CNT_W'((1 << postCode) - 1);
  end

  // R7: an error flag implies a slow postscaler code with USB on
  a_r7_err_cause: assert property (@(posedge clkPll) disable iff (rst)
    cfgErr |-> (usbEnable && postCode[POST_CODE_W-1]));
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int USB_DIV = 2,
  parameter int SYS_DIV = 3
) (
  input  logic     clkOsc,
  input  logic     clkPll,
  input  logic     rst,
  input  divCtrl_t ctrl,
  output logic     refEn,
  output logic     usbClkEn,
  output logic     sysClkEn
);
  localparam int USB_W = (USB_DIV > 1) ? $clog2(USB_DIV) : 1;
  localparam int SYS_W = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;

  logic [PRE_CNT_W-1:0]  preCnt;
  logic [USB_W-1:0]      usbCnt;
  logic [SYS_W-1:0]      stageCnt;
  logic [POST_CNT_W-1:0] postCnt;
  logic preWrap, usbWrap, stageWrap, postWrap;

  always_comb begin
    preWrap   = (preCnt == ctrl.preLast);
    usbWrap   = (usbCnt == USB_W'(USB_DIV - 1));
    stageWrap = (stageCnt == SYS_W'(SYS_DIV - 1));
    postWrap  = (postCnt == ctrl.postLast);
  end

  // Prescaler: oscillator domain
  always_ff @(posedge clkOsc) begin
    if (rst || !ctrl.preRun || ctrl.preRestart) begin
      preCnt <= '0;
      refEn  <= 1'b0;
    end else begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
      refEn  <= preWrap;
    end
  end

  // Fixed USB branch, gated at the output only
  always_ff @(posedge clkPll) begin
    if (rst) begin
      usbCnt   <= '0;
      usbClkEn <= 1'b0;
    end else begin
      usbCnt   <= usbWrap ? '0 : usbCnt + 1'b1;
      usbClkEn <= usbWrap && ctrl.usbActive;
    end
  end

  // System branch: fixed stage then postscaler
  always_ff @(posedge clkPll) begin
    if (rst || ctrl.sysRestart) begin
      stageCnt <= '0;
      postCnt  <= '0;
      sysClkEn <= 1'b0;
    end else begin
      stageCnt <= stageWrap ? '0 : stageCnt + 1'b1;
      if (stageWrap) postCnt <= postWrap ? '0 : postCnt + 1'b1;
      sysClkEn <= stageWrap && postWrap;
    end
  end

  a_r3_idle_when_invalid: assert property (@(posedge clkOsc) disable iff (rst)
    !ctrl.preRun |=> !refEn);
  a_r8_restart_quiet: assert property (@(posedge clkOsc) disable iff (rst)
    ctrl.preRestart |=> !refEn);
  a_r5_usb_gated: assert property (@(posedge clkPll) disable iff (rst)
    !ctrl.usbActive |=> !usbClkEn);
  a_r10_usb_single: assert property (@(posedge clkPll) disable iff (rst)
    usbClkEn |=> !usbClkEn);
  a_r10_sys_single: assert property (@(posedge clkPll) disable iff (rst)
    sysClkEn |=> !sysClkEn);
  a_r9_sys_restart_quiet: assert property (@(posedge clkPll) disable iff (rst)
    ctrl.sysRestart |=> !sysClkEn);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int USB_DIV = 2,
  parameter int SYS_DIV = 3
) (
  input  logic                   clkOsc,
  input  logic                   clkPll,
  input  logic                   rst,
  input  logic [PRE_CODE_W-1:0]  preCode,
  input  logic                   srcIsRc,
  input  logic [POST_CODE_W-1:0] postCode,
  input  logic                   usbEnable,
  input  logic                   usbSuspend,
  output logic                   refEn,
  output logic                   preCodeValid,
  output logic                   usbClkEn,
  output logic                   sysClkEn,
  output logic                   cfgErr
);
  divCtrl_t ctrl;

  clkdiv_ctrl u_ctrl (
    .clkOsc(clkOsc), .clkPll(clkPll), .rst(rst),
    .preCode(preCode), .srcIsRc(srcIsRc), .postCode(postCode),
    .usbEnable(usbEnable), .usbSuspend(usbSuspend),
    .ctrl(ctrl), .preCodeValid(preCodeValid), .cfgErr(cfgErr)
  );

  clkdiv_datapath #(.USB_DIV(USB_DIV), .SYS_DIV(SYS_DIV)) u_dp (
    .clkOsc(clkOsc), .clkPll(clkPll), .rst(rst), .ctrl(ctrl),
    .refEn(refEn), .usbClkEn(usbClkEn), .sysClkEn(sysClkEn)
  );
endmodule

// File: tb/clkdiv_top_tb.sv
module clkdiv_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] preCode = 4'd0;
  logic srcIsRc = 1'b0;
  logic [1:0] postCode = 2'd0;
  logic usbEnable = 1'b0, usbSuspend = 1'b0;
  logic refEn, preCodeValid, usbClkEn, sysClkEn, cfgErr;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  clkdiv_top u_dut (
    .clkOsc(clk), .clkPll(clk), .rst(rst),
    .preCode(preCode), .srcIsRc(srcIsRc), .postCode(postCode),
    .usbEnable(usbEnable), .usbSuspend(usbSuspend),
    .refEn(refEn), .preCodeValid(preCodeValid), .usbClkEn(usbClkEn),
    .sysClkEn(sysClkEn), .cfgErr(cfgErr)
  );

  // Behavioural reference: edges counted since last restart
  int preAge = 0, usbAge = 0, sysAge = 0;
  int mPrevPre = 0, mPrevPost = 0;
  bit expRef = 0, expUsb = 0, expSys = 0;
  bit lastSys = 0, lastUsb = 0;

  function automatic int ratioOf(int code);
    int table_q[$] = '{1, 2, 3, 4, 5, 6, 8, 12};
    return table_q[code];
  endfunction

  function automatic bit validOf(int code, bit rc);
    return (code < 8) && (!rc || code < 2);
  endfunction

  always @(posedge clk) begin
    bit changed;
    changed = (int'(preCode) != mPrevPre);
    mPrevPre = int'(preCode);
    if (rst || changed || !validOf(int'(preCode), srcIsRc)) begin
      preAge = 0; expRef = 0;
    end else begin
      preAge++; expRef = (preAge % ratioOf(int'(preCode))) == 0;
    end
    if (rst) begin
      usbAge = 0; expUsb = 0;
    end else begin
      usbAge++; expUsb = (usbAge % 2 == 0) && usbEnable && !usbSuspend;
    end
    changed = (int'(postCode) != mPrevPost);
    mPrevPost = int'(postCode);
    if (rst || changed) begin
      sysAge = 0; expSys = 0;
    end else begin
      sysAge++; expSys = (sysAge % (3 * (1 << postCode))) == 0;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(phase, "refEn", refEn, expRef);
      check(phase, "preCodeValid", preCodeValid, validOf(int'(preCode), srcIsRc));
      check(phase, "usbClkEn", usbClkEn, expUsb);
      check(phase, "sysClkEn", sysClkEn, expSys);
      check(phase, "cfgErr", cfgErr, usbEnable && postCode[1]);
      // R10: single-cycle pulses for ratios above 1
      if (!rst && postCode != 0 || !rst) check("R10", "sys pulse width", sysClkEn && lastSys, 0);
      check("R10", "usb pulse width", usbClkEn && lastUsb, 0);
      lastSys = sysClkEn;
      lastUsb = usbClkEn;
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    phase = "R1";
    waitCycles(4);
    rst = 1'b0;
    usbEnable = 1'b1;
    // R2: sweep all legal prescaler codes
    phase = "R2";
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); preCode = 4'(c);
      waitCycles(40);
    end
    // R3: reserved codes
    phase = "R3";
    for (int c = 8; c < 16; c += 3) begin
      @(negedge clk); preCode = 4'(c);
      waitCycles(15);
    end
    // R4: internal RC source
    phase = "R4";
    srcIsRc = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); preCode = 4'(c);
      waitCycles(20);
    end
    srcIsRc = 1'b0;
    // R8: change code on the cycle a pulse is due
    phase = "R8";
    preCode = 4'd2;
    waitCycles(8);
    for (int k = 0; k < 30 && !refEn; k++) waitCycles(1);
    waitCycles(2);
    preCode = 4'd7;
    waitCycles(30);
    preCode = 4'd6;
    waitCycles(5);
    preCode = 4'd4;
    waitCycles(20);
    // R6 / R7: postscaler sweep with USB on and off
    phase = "R6";
    for (int u = 0; u < 2; u++) begin
      usbEnable = 1'(u);
      for (int p = 0; p < 4; p++) begin
        @(negedge clk); postCode = 2'(p);
        phase = (p >= 2) ? "R7" : "R6";
        waitCycles(60);
      end
    end
    // R9: change postscaler mid-period and on a due pulse
    phase = "R9";
    postCode = 2'd1;
    waitCycles(5);
    postCode = 2'd3;
    waitCycles(23);
    postCode = 2'd2;
    waitCycles(30);
    // R5: USB gating, coinciding with a postscaler change
    phase = "R5";
    usbSuspend = 1'b1;
    waitCycles(10);
    usbSuspend = 1'b0; postCode = 2'd3;
    waitCycles(10);
    usbEnable = 1'b0; postCode = 2'd0;
    waitCycles(10);
    usbEnable = 1'b1;
    waitCycles(10);
    // R1: reset mid-run
    phase = "R1";
    rst = 1'b1;
    waitCycles(3);
    rst = 1'b0;
    waitCycles(30);
    finishRun();
  end
endmodule